// File: doc/BRIEF.md
# Execution unit busy tracker

This block keeps track of which execution units are occupied in an out-of-order issue stage. Units are collected into leaf resources, and each leaf has `UNITS` identical units. Groups are sets of two or more leaves, and they are described by a membership bitmap parameter. When an instruction issues, the caller names one leaf and one unit in that leaf, and gives a cycle count. That unit then stays busy for the given number of cycles. The caller can instead name a group and reserve the whole group for a number of cycles. Unit selection is done outside the block.

On every clock edge, each non-zero busy counter counts down. When a counter expires, its unit or group becomes free again, and the block raises a one-cycle pulse for the owning resource. Each group keeps its own registered view of which member leaves still have a free unit. A member is dropped from that view when its last free unit is taken. It is added back when one of its units is freed. A resource is ready for a request that needs N units when it has at least N free units; for a group, that means at least N available member leaves. A group under reservation is never ready. A request that itself reserves counts as needing zero units.

Top module: `exec_busy_tracker`

## Requirements
- R1: An issue with a cycle count of 0 changes no counter, no reservation and no pulse.
- R2: A non-reserved issue to leaf `l` (resource IDs 0..NUM_LEAF-1) with exactly one bit set in `iss_unit` makes that unit busy from the next edge. The issue adds the cycle count to whatever the counter holds after this cycle's decrement, saturating at 2^CNT_W-1.
- R3: When a leaf loses its last free unit, every group that contains it shows that leaf as unavailable from the same edge.
- R4: When a leaf that had no free unit frees one, every group that contains it shows that leaf as available again from the same edge.
- R5: A reserved issue to group `g` (resource ID NUM_LEAF+g) reserves the whole group for the cycle count. While a group is reserved, its `res_ready` bit is 0 for every request.
- R6: An issue is ignored if it is reserved but names a leaf, non-reserved but names a group, non-reserved with a unit field that is not one-hot, or names an ID of NUM_LEAF+NUM_GRP or above.
- R7: Every non-zero counter drops by one at each edge. A counter that reaches zero frees its unit (for a leaf) or ends the reservation (for a group). The same edge sets bit `i` of `res_freed` for one cycle, where `i` is the resource ID.
- R8: With `need_resv`=0, `res_ready[i]` is 1 when the free count of resource `i` is at least `need_units`. The free count is the number of idle units for a leaf, and the number of available member leaves for an unreserved group.
- R9: With `need_resv`=1, `res_ready[i]` is 1 for every leaf and for every group that is not reserved.
- R10: If an issue hits a unit in the same cycle that its counter expires, the new issue wins. The unit stays busy, and that expiry produces no freed pulse.
- R11: After reset every unit is idle, no group is reserved, every member leaf is available, and `res_freed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present this cycle |
| iss_res | input | RES_W | Resource ID: leaves first, then groups |
| iss_unit | input | UNITS | One-hot unit within the named leaf |
| iss_cycles | input | CNT_W | Busy cycles to add |
| iss_resv | input | 1 | Reserve the whole named group |
| need_units | input | NEED_W | Unit count for the readiness query |
| need_resv | input | 1 | Query is for a reserving use (needs zero units) |
| res_ready | output | NUM_LEAF+NUM_GRP | Per-resource readiness for the current query |
| res_freed | output | NUM_LEAF+NUM_GRP | Per-resource pulse: a counter expired at the last edge |

## Verification
The hardest situations to reach are a group's view of a leaf changing at the same edge that the leaf fills up or frees a unit, and an issue that lands on a unit in the very cycle its counter expires. The bench gets there with directed sequences: it fills both units of a leaf that two groups share, with different cycle counts, then lets them drain. It also issues to a unit whose counter stands at 1. A sweep then drives every resource ID, every unit pattern, several cycle counts and both reserve settings back to back, so that counters overlap and expire in mixed orders. After each edge the bench compares all readiness queries and the freed pulses with its own arithmetic model.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  // Saturating sum used for busy counters.
  function automatic int unsigned ubt_sat_sum(int unsigned a, int unsigned b,
                                              int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

endpackage

// File: rtl/ubt_unit_ctr.sv
module ubt_unit_ctr
  import ubt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] add,
  output logic             busy,
  output logic             busy_nxt,
  output logic             expire
);
  localparam int unsigned CNT_MAX = (32'd1 << CNT_W) - 32'd1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] sum;
  logic             eff_load;

  assign eff_load = load && (add != '0);

  always_comb begin
    dec = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
    sum = CNT_W'(ubt_sat_sum(32'(dec), 32'(add), CNT_MAX));
  end

  assign busy     = (cnt_q != '0);
  assign busy_nxt = eff_load || (cnt_q > CNT_W'(1));
  assign expire   = (cnt_q == CNT_W'(1)) && !eff_load;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (eff_load) cnt_q <= sum;
    else               cnt_q <= dec;
  end

  p_busy_after_load_r2: assert property (@(posedge clk) disable iff (rst)
    eff_load |=> busy);
  p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !eff_load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !eff_load) |=> !busy);
  p_expire_ends_r7: assert property (@(posedge clk) disable iff (rst)
    expire |=> !busy);

endmodule

// File: rtl/ubt_leaf_res.sv
module ubt_leaf_res #(
  parameter int UNITS  = 2,
  parameter int CNT_W  = 8,
  parameter int CNT_UW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [UNITS-1:0]  hit_unit,
  input  logic [CNT_W-1:0]  add,
  output logic [CNT_UW-1:0] free_cnt,
  output logic              has_free,
  output logic              has_free_nxt,
  output logic              freed_q
);
  logic [UNITS-1:0] busy;
  logic [UNITS-1:0] busy_nxt;
  logic [UNITS-1:0] expire;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    ubt_unit_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (hit && hit_unit[u]),
      .add      (add),
      .busy     (busy[u]),
      .busy_nxt (busy_nxt[u]),
      .expire   (expire[u])
    );
  end

  always_comb begin
    free_cnt = '0;
    for (int u = 0; u < UNITS; u++)
      if (!busy[u]) free_cnt = free_cnt + CNT_UW'(1);
  end

  assign has_free     = ~&busy;
  assign has_free_nxt = ~&busy_nxt;

  always_ff @(posedge clk) begin
    if (rst) freed_q <= 1'b0;
    else     freed_q <= |expire;
  end

  p_freed_room_r7: assert property (@(posedge clk) disable iff (rst)
    freed_q |-> has_free);

endmodule

// File: rtl/ubt_grp_res.sv
module ubt_grp_res #(
  parameter int                  NUM_LEAF = 4,
  parameter logic [NUM_LEAF-1:0] MEMBERS  = 4'b0011,
  parameter int                  CNT_W    = 8,
  parameter int                  CNT_UW   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  logic [CNT_W-1:0]    add,
  input  logic [NUM_LEAF-1:0] full_evt,
  input  logic [NUM_LEAF-1:0] regain_evt,
  output logic                reserved,
  output logic [NUM_LEAF-1:0] avail_q,
  output logic [CNT_UW-1:0]   avail_cnt,
  output logic                freed_q
);
  logic resv_nxt;
  logic resv_exp;

  ubt_unit_ctr #(.CNT_W(CNT_W)) u_resv (
    .clk      (clk),
    .rst      (rst),
    .load     (hit),
    .add      (add),
    .busy     (reserved),
    .busy_nxt (resv_nxt),
    .expire   (resv_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= MEMBERS;
      freed_q <= 1'b0;
    end else begin
      avail_q <= (avail_q & ~(full_evt & MEMBERS)) | (regain_evt & MEMBERS);
      freed_q <= resv_exp;
    end
  end

  always_comb begin
    avail_cnt = '0;
    for (int l = 0; l < NUM_LEAF; l++)
      if (avail_q[l]) avail_cnt = avail_cnt + CNT_UW'(1);
  end

  p_resv_take_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && add != '0) |=> reserved);
  p_resv_next_r5: assert property (@(posedge clk) disable iff (rst)
    resv_nxt |=> reserved);

endmodule

// File: rtl/exec_busy_tracker.sv
module exec_busy_tracker #(
  parameter int NUM_LEAF = 4,
  parameter int UNITS    = 2,
  parameter int NUM_GRP  = 2,
  parameter logic [NUM_GRP*NUM_LEAF-1:0] GRP_MAP = 8'b1110_0011,
  parameter int CNT_W    = 8,
  localparam int NUM_RES = NUM_LEAF + NUM_GRP,
  localparam int RES_W   = $clog2(NUM_RES),
  localparam int MAX_CNT = (UNITS > NUM_LEAF) ? UNITS : NUM_LEAF,
  localparam int NEED_W  = $clog2(MAX_CNT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iss_valid,
  input  logic [RES_W-1:0]   iss_res,
  input  logic [UNITS-1:0]   iss_unit,
  input  logic [CNT_W-1:0]   iss_cycles,
  input  logic               iss_resv,
  input  logic [NEED_W-1:0]  need_units,
  input  logic               need_resv,
  output logic [NUM_RES-1:0] res_ready,
  output logic [NUM_RES-1:0] res_freed
);
  logic                unit_ok;
  logic                cyc_ok;
  logic [NUM_LEAF-1:0] leaf_hit;
  logic [NUM_LEAF-1:0] leaf_has_free;
  logic [NUM_LEAF-1:0] leaf_has_free_nxt;
  logic [NUM_LEAF-1:0] leaf_freed;
  logic [NUM_LEAF-1:0] full_evt;
  logic [NUM_LEAF-1:0] regain_evt;
  logic [NEED_W-1:0]   leaf_free [NUM_LEAF];
  logic [NUM_GRP-1:0]  grp_hit;
  logic [NUM_GRP-1:0]  grp_resv;
  logic [NUM_GRP-1:0]  grp_freed;
  logic [NUM_LEAF-1:0] grp_avail [NUM_GRP];
  logic [NEED_W-1:0]   grp_cnt [NUM_GRP];

  assign unit_ok = $onehot(iss_unit);
  assign cyc_ok  = (iss_cycles != '0);

  for (genvar l = 0; l < NUM_LEAF; l++) begin : g_leaf
    assign leaf_hit[l] = iss_valid && !iss_resv && unit_ok && cyc_ok &&
                         (iss_res == RES_W'(l));
    ubt_leaf_res #(.UNITS(UNITS), .CNT_W(CNT_W), .CNT_UW(NEED_W)) u_leaf (
      .clk          (clk),
      .rst          (rst),
      .hit          (leaf_hit[l]),
      .hit_unit     (iss_unit),
      .add          (iss_cycles),
      .free_cnt     (leaf_free[l]),
      .has_free     (leaf_has_free[l]),
      .has_free_nxt (leaf_has_free_nxt[l]),
      .freed_q      (leaf_freed[l])
    );
    assign full_evt[l]   = leaf_has_free[l] && !leaf_has_free_nxt[l];
    assign regain_evt[l] = !leaf_has_free[l] && leaf_has_free_nxt[l];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_hit[g] = iss_valid && iss_resv && cyc_ok &&
                        (iss_res == RES_W'(NUM_LEAF + g));
    ubt_grp_res #(
      .NUM_LEAF (NUM_LEAF),
      .MEMBERS  (GRP_MAP[g*NUM_LEAF +: NUM_LEAF]),
      .CNT_W    (CNT_W),
      .CNT_UW   (NEED_W)
    ) u_grp (
      .clk        (clk),
      .rst        (rst),
      .hit        (grp_hit[g]),
      .add        (iss_cycles),
      .full_evt   (full_evt),
      .regain_evt (regain_evt),
      .reserved   (grp_resv[g]),
      .avail_q    (grp_avail[g]),
      .avail_cnt  (grp_cnt[g]),
      .freed_q    (grp_freed[g])
    );

    for (genvar l = 0; l < NUM_LEAF; l++) begin : g_chk
      if (GRP_MAP[g*NUM_LEAF + l]) begin : g_mem
        p_member_view_r3: assert property (@(posedge clk) disable iff (rst)
          grp_avail[g][l] == leaf_has_free[l]);
        p_member_back_r4: assert property (@(posedge clk) disable iff (rst)
          $rose(leaf_has_free[l]) |-> grp_avail[g][l]);
      end else begin : g_non
        p_nonmember_r3: assert property (@(posedge clk) disable iff (rst)
          !grp_avail[g][l]);
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_LEAF; l++)
      res_ready[l] = need_resv || (leaf_free[l] >= need_units);
    for (int g = 0; g < NUM_GRP; g++)
      res_ready[NUM_LEAF + g] = !grp_resv[g] &&
                                (need_resv || (grp_cnt[g] >= need_units));
  end

  assign res_freed = {grp_freed, leaf_freed};

endmodule

// File: tb/exec_busy_tracker_tb.sv
`timescale 1ns/1ps
module exec_busy_tracker_tb;
  localparam int NL = 4, UN = 2, NG = 2, CW = 8, NR = 6, RW = 3, NW = 3;
  localparam logic [7:0] MAP = 8'b1110_0011;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [RW-1:0] iss_res = '0;
  logic [UN-1:0] iss_unit = '0;
  logic [CW-1:0] iss_cycles = '0;
  logic iss_resv = 1'b0;
  logic [NW-1:0] need_units = '0;
  logic need_resv = 1'b0;
  logic [NR-1:0] res_ready;
  logic [NR-1:0] res_freed;

  int m_cnt [NL][UN];
  int m_g [NG];
  logic [NR-1:0] m_freed;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exec_busy_tracker u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_res(iss_res),
    .iss_unit(iss_unit), .iss_cycles(iss_cycles), .iss_resv(iss_resv),
    .need_units(need_units), .need_resv(need_resv),
    .res_ready(res_ready), .res_freed(res_freed)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [NR-1:0] exp_ready(int need, bit nr);
    logic [NR-1:0] r;
    for (int l = 0; l < NL; l++) begin
      int f = 0;
      for (int u = 0; u < UN; u++) if (m_cnt[l][u] == 0) f++;
      r[l] = nr || (f >= need);
    end
    for (int g = 0; g < NG; g++) begin
      int a = 0;
      for (int l = 0; l < NL; l++) begin
        bit lf = (m_cnt[l][0] == 0) || (m_cnt[l][1] == 0);
        if (MAP[g*NL+l] && lf) a++;
      end
      r[NL+g] = (m_g[g] == 0) && (nr || (a >= need));
    end
    return r;
  endfunction

  task automatic model_step(bit v, int res, logic [UN-1:0] unit, int cyc, bit rv);
    m_freed = '0;
    for (int l = 0; l < NL; l++)
      for (int u = 0; u < UN; u++) begin
        bit hit = v && !rv && res == l && unit[u] && $onehot(unit) && cyc != 0;
        int dec = (m_cnt[l][u] > 0) ? m_cnt[l][u] - 1 : 0;
        if (m_cnt[l][u] == 1 && !hit) m_freed[l] = 1'b1;
        m_cnt[l][u] = hit ? ((dec + cyc > CMAX) ? CMAX : dec + cyc) : dec;
      end
    for (int g = 0; g < NG; g++) begin
      bit hit = v && rv && res == NL + g && cyc != 0;
      int dec = (m_g[g] > 0) ? m_g[g] - 1 : 0;
      if (m_g[g] == 1 && !hit) m_freed[NL+g] = 1'b1;
      m_g[g] = hit ? ((dec + cyc > CMAX) ? CMAX : dec + cyc) : dec;
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " freed"}, int'(res_freed), int'(m_freed));
    for (int need = 0; need < 4; need++)
      for (int nr = 0; nr < 2; nr++) begin
        need_units = NW'(need);
        need_resv = nr[0];
        #0.5;
        chk($sformatf("%s/%s ready need=%0d", tag, nr ? "R9" : "R8", need),
            int'(res_ready), int'(exp_ready(need, nr[0])));
      end
  endtask

  task automatic step(string tag, bit v, int res, logic [UN-1:0] unit, int cyc, bit rv);
    iss_valid = v; iss_res = RW'(res); iss_unit = unit;
    iss_cycles = CW'(cyc); iss_resv = rv;
    @(posedge clk);
    model_step(v, res, unit, cyc, rv);
    @(negedge clk);
    iss_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, '0, 0, 0);
  endtask

  initial begin
    int cyc_set [4] = '{0, 1, 2, 5};
    for (int l = 0; l < NL; l++) for (int u = 0; u < UN; u++) m_cnt[l][u] = 0;
    for (int g = 0; g < NG; g++) m_g[g] = 0;
    m_freed = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R11");

    step("R2", 1, 0, 2'b01, 3, 0);
    idle("R7", 3);
    step("R1", 1, 1, 2'b01, 0, 0);
    step("R1", 1, 4, 2'b00, 0, 1);
    step("R3", 1, 1, 2'b01, 2, 0);
    step("R3", 1, 1, 2'b10, 4, 0);
    idle("R4", 5);
    step("R5", 1, 4, 2'b00, 3, 1);
    idle("R5", 4);
    step("R5", 1, 5, 2'b00, 2, 1);
    step("R5", 1, 2, 2'b01, 2, 0);
    idle("R5", 3);
    step("R6", 1, 0, 2'b01, 3, 1);
    step("R6", 1, 4, 2'b01, 3, 0);
    step("R6", 1, 2, 2'b11, 3, 0);
    step("R6", 1, 3, 2'b00, 3, 0);
    step("R6", 1, 7, 2'b01, 3, 1);
    idle("R6", 2);
    step("R10", 1, 2, 2'b01, 1, 0);
    step("R10", 1, 2, 2'b01, 2, 0);
    idle("R10", 3);
    step("R2", 1, 3, 2'b10, 200, 0);
    step("R2", 1, 3, 2'b10, 200, 0);
    idle("R7", 258);

    for (int res = 0; res < 8; res++)
      for (int un = 0; un < 4; un++)
        for (int ci = 0; ci < 4; ci++)
          for (int rv = 0; rv < 2; rv++)
            step("R8", 1, res, UN'(un), cyc_set[ci], rv[0]);
    idle("R7", 8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule